// File: doc/BRIEF.md
# Timed Enable Output Port Controller

This block drives six digital enable lines for the receiver, transmitter and power amplifier stages that sit outside the chip in a time-slotted radio. A slot timing sequencer supplies a 6-bit automatic enable word each clock. A host may take any single line away from the sequencer and set its level directly. A per-line polarity control inverts whatever level was selected, so that active-low and active-high external parts can share the same port.

The host writes three byte-wide configuration registers through a plain write strobe with an 8-bit address and 8-bit data. The registers cannot be read back. One register holds the host levels, one holds the per-line source selection, and one holds the per-line inversion. The six output lines come straight from flip-flops, so no combinational path from the host bus or the sequencer input reaches the pins.

Top module: `enab_port_ctrl`

## Requirements
- R1: Only bits 5:0 of a written byte are used, with bit n controlling output line n. Bits 7:6 are dropped on every write, and setting them changes no output line.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored into the host-level register if `wr_addr` is 0x90, into the source-select register if it is 0x91, and into the polarity register if it is 0x92.
- R3: A line whose source-select bit is 1 takes its level from the matching host-level bit.
- R4: A line whose source-select bit is 0 follows the matching bit of `auto_en`. Writing its host-level bit does not change that line.
- R5: A line whose polarity bit is 1 shows the complement of its selected source. This applies whether the line is host-driven or automatic.
- R6: When reset is released, all three registers hold zero. Every line then follows `auto_en` without inversion until the host writes.
- R7: A write to any address other than 0x90, 0x91 or 0x92 changes no register and no output line.
- R8: A change of `auto_en`, or a register write, sampled at one rising edge is visible on `en_o` right after that same edge. Without a new change, `en_o` then holds that level.
- R9: While `rst_n` is low, the registers are cleared at once, and `en_o` keeps loading `auto_en` uninverted at every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, sampled on the rising edge |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| auto_en | input | 6 | Enable word from the slot timing sequencer |
| en_o | output | 6 | Registered enable output lines |

## Verification
The sequencer input is first driven through walking-one, walking-zero, all-set and alternating words while no line is host-driven. This shows that every line follows its own automatic bit and that no lines are swapped. Source-select words that mix host-driven and automatic lines are then applied while the automatic input and the host levels toggle out of phase. That separates a line wrongly taken from the host from one wrongly taken from the sequencer. Polarity words are applied over both kinds of line, which shows that inversion comes after the source choice. Writes to neighbouring and unrelated addresses, writes with the reserved bits set, and a reset asserted in the middle of a run show that no stray write lands in a register and that reset clears all of the configuration.

// File: rtl/enab_pkg.sv
package enab_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LVL  = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_POL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/enab_rst_sync.sv
module enab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_s = shift_q[STAGES-1];
endmodule

// File: rtl/enab_cfg_regs.sv
module enab_cfg_regs
  import enab_pkg::*;
#(
  parameter int          NUM_PINS = 6,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  LVL_ADDR = 8'h90,
  parameter logic [7:0]  SRC_ADDR = 8'h91,
  parameter logic [7:0]  POL_ADDR = 8'h92
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_n_s,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] lvl_q,
  output logic [NUM_PINS-1:0] src_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] lvl_nx,
  output logic [NUM_PINS-1:0] src_nx,
  output logic [NUM_PINS-1:0] pol_nx
);
  reg_sel_e            sel;
  logic                lvl_ce, src_ce, pol_ce;
  logic [NUM_PINS-1:0] load_val;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == LVL_ADDR[ADDR_W-1:0])      sel = SEL_LVL;
      else if (wr_addr == SRC_ADDR[ADDR_W-1:0]) sel = SEL_SRC;
      else if (wr_addr == POL_ADDR[ADDR_W-1:0]) sel = SEL_POL;
    end
  end

  // Clock enables: a decoded write, or the synchronised reset that clears
  always_comb begin
    lvl_ce   = (sel == SEL_LVL) || !rst_n_s;
    src_ce   = (sel == SEL_SRC) || !rst_n_s;
    pol_ce   = (sel == SEL_POL) || !rst_n_s;
    load_val = rst_n_s ? wr_data[NUM_PINS-1:0] : '0;
  end

  // Values the registers will hold after this edge
  always_comb begin
    lvl_nx = lvl_ce ? load_val : lvl_q;
    src_nx = src_ce ? load_val : src_q;
    pol_nx = pol_ce ? load_val : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      src_q <= '0;
      pol_q <= '0;
    end else begin
      if (lvl_ce) lvl_q <= load_val;
      if (src_ce) src_q <= load_val;
      if (pol_ce) pol_q <= load_val;
    end
  end
endmodule

// File: rtl/enab_pin_mux.sv
module enab_pin_mux #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] src,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] auto_en,
  output logic [NUM_PINS-1:0] pin_q
);
  logic [NUM_PINS-1:0] pin_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic chosen;
    always_comb begin
      chosen   = src[i] ? lvl[i] : auto_en[i];
      pin_d[i] = chosen ^ pol[i];
    end
  end

  // No reset: the line keeps tracking the sequencer while reset is held
  always_ff @(posedge clk) begin
    pin_q <= pin_d;
  end
endmodule

// File: rtl/enab_port_ctrl.sv
module enab_port_ctrl #(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [5:0]        auto_en,
  output logic [5:0]        en_o
);
  localparam int SYNC_STAGES = 2;

  logic                rst_n_s;
  logic [NUM_PINS-1:0] lvl_q, src_q, pol_q;
  logic [NUM_PINS-1:0] lvl_nx, src_nx, pol_nx;
  logic [NUM_PINS-1:0] pin_q;

  enab_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  enab_cfg_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lvl_q   (lvl_q),
    .src_q   (src_q),
    .pol_q   (pol_q),
    .lvl_nx  (lvl_nx),
    .src_nx  (src_nx),
    .pol_nx  (pol_nx)
  );

  enab_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .clk     (clk),
    .lvl     (lvl_nx),
    .src     (src_nx),
    .pol     (pol_nx),
    .auto_en (auto_en[NUM_PINS-1:0]),
    .pin_q   (pin_q)
  );

  assign en_o = pin_q;
endmodule

// File: rtl/enab_port_chk.sv
module enab_port_chk #(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [NUM_PINS-1:0] auto_en,
  input logic [NUM_PINS-1:0] en_o,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic [NUM_PINS-1:0] src_q,
  input logic [NUM_PINS-1:0] pol_q
);
  logic bad_addr;
  assign bad_addr = wr_en && (wr_addr != 8'h90) && (wr_addr != 8'h91) && (wr_addr != 8'h92);

  // R3: host-driven lines show the stored host level, after polarity
  a_r3_host_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_o ^ pol_q) & src_q) == (lvl_q & src_q));

  // R4: automatic lines show the sequencer word sampled one edge earlier
  a_r4_auto_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_o ^ pol_q) & ~src_q) == ($past(auto_en) & ~src_q));

  // R5: a polarity-only change flips exactly the lines whose polarity changed
  a_r5_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lvl_q) && $stable(src_q) && ($past(auto_en) == $past(auto_en, 2)))
      |-> ((en_o ^ $past(en_o)) == (pol_q ^ $past(pol_q))));

  // R7: a write to an unknown address leaves every register alone
  a_r7_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |=> ($stable(lvl_q) && $stable(src_q) && $stable(pol_q)));
endmodule

bind enab_port_ctrl enab_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .auto_en (auto_en[NUM_PINS-1:0]),
  .en_o    (en_o[NUM_PINS-1:0]),
  .lvl_q   (lvl_q),
  .src_q   (src_q),
  .pol_q   (pol_q)
);

// File: tb/tb_enab_port_ctrl.sv
module tb_enab_port_ctrl;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [5:0] auto_en;
  logic [5:0] en_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R6";

  // Behavioural reference state
  logic [5:0] m_lvl = 6'd0, m_src = 6'd0, m_pol = 6'd0, m_out = 6'd0;
  int         m_rel_edges = 0;   // edges seen with reset released
  bit         m_valid = 0;
  bit         done = 0;

  enab_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .auto_en(auto_en), .en_o(en_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model: registers clear while reset is low and for the
  // two edges it takes the release to pass the synchroniser.
  always @(posedge clk) begin
    logic [5:0] sel;
    if (!rst_n) begin
      m_rel_edges = 0;
      m_lvl = 0; m_src = 0; m_pol = 0;
    end else begin
      if (m_rel_edges < 2) begin
        m_lvl = 0; m_src = 0; m_pol = 0;
      end else if (wr_en) begin
        case (wr_addr)
          8'h90: m_lvl = wr_data[5:0];
          8'h91: m_src = wr_data[5:0];
          8'h92: m_pol = wr_data[5:0];
          default: ;
        endcase
      end
      if (m_rel_edges < 10) m_rel_edges++;
    end
    sel = (m_src & m_lvl) | (~m_src & auto_en);
    m_out = sel ^ m_pol;
    m_valid = 1;
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      checks++;
      if (en_o !== m_out) begin
        errors++;
        $display("FAIL %s: en_o=%b expected=%b at %0t", cur_req, en_o, m_out, $time);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
  endtask

  task automatic expect_pins(input logic [5:0] exp, input string req);
    checks++;
    if (en_o !== exp) begin
      errors++;
      $display("FAIL %s: en_o=%b expected=%b", req, en_o, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00; auto_en = 6'h00;
    // R9: while in reset the lines follow the sequencer one edge later
    cur_req = "R9";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      auto_en = 6'h01 << i;
      @(negedge clk);
      expect_pins(6'h01 << i, "R9");
    end
    rst_n = 1'b1;
    tick(4);

    // R6: after release, no host control and no inversion
    cur_req = "R6";
    auto_en = 6'h2A; tick(1); expect_pins(6'h2A, "R6");

    // R8 / R4: walking patterns on the sequencer input
    cur_req = "R8";
    for (int i = 0; i < 6; i++) begin
      auto_en = ~(6'h01 << i); tick(1); expect_pins(~(6'h01 << i), "R8");
    end
    auto_en = 6'h3F; tick(1);
    auto_en = 6'h15; tick(1); expect_pins(6'h15, "R8");
    tick(3); expect_pins(6'h15, "R8");

    // R4: host level writes on automatic lines do nothing
    cur_req = "R4";
    host_wr(8'h90, 8'h3F); expect_pins(6'h15, "R4");
    host_wr(8'h90, 8'h00); expect_pins(6'h15, "R4");

    // R2 / R3: select host on lines 0,2,5 ; level 1 on those
    cur_req = "R3";
    host_wr(8'h90, 8'h25);
    host_wr(8'h91, 8'h25);
    auto_en = 6'h00; tick(1); expect_pins(6'h25, "R3");
    auto_en = 6'h3F; tick(1); expect_pins(6'h3F, "R3");
    host_wr(8'h90, 8'h00); expect_pins(6'h1A, "R3");

    // R5: inversion over both kinds of line
    cur_req = "R5";
    host_wr(8'h92, 8'h0F);
    auto_en = 6'h3F; tick(1); expect_pins(6'h3F ^ 6'h0F ^ 6'h25, "R5");
    for (int i = 0; i < 6; i++) begin
      auto_en = 6'h01 << i; tick(2);
    end

    // R7: stray addresses are ignored
    cur_req = "R7";
    host_wr(8'h93, 8'h3F);
    host_wr(8'h8F, 8'h3F);
    host_wr(8'h10, 8'h3F);
    host_wr(8'h00, 8'h3F);
    host_wr(8'h12, 8'h00);
    auto_en = 6'h00; tick(1); expect_pins(6'h0F ^ 6'h00, "R7");

    // R1: reserved bits dropped
    cur_req = "R1";
    host_wr(8'h92, 8'hC0);
    host_wr(8'h91, 8'hC0);
    auto_en = 6'h2D; tick(1); expect_pins(6'h2D, "R1");
    host_wr(8'h91, 8'hFF);
    host_wr(8'h90, 8'hD5); expect_pins(6'h15, "R1");

    // R9: reset in mid-run clears everything
    cur_req = "R9";
    host_wr(8'h92, 8'h3F);
    rst_n = 1'b0; auto_en = 6'h33; tick(2); expect_pins(6'h33, "R9");
    rst_n = 1'b1; tick(3);
    cur_req = "R6";
    auto_en = 6'h0C; tick(1); expect_pins(6'h0C, "R6");
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: en_o=%b expected=finish", en_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule